// File: doc/BRIEF.md
# Table-Driven Header Identification Engine

This block walks a packet's header chain under a parse graph that software loads at run time. The graph is held as a state-transition table of 32 entries. Each entry is a ternary key (value plus care mask), and a RAM word of actions sits beside it. The header region of the packet is presented as a 64-byte window. The engine keeps a current state, a byte cursor into the window and two lookup offsets. Every cycle it takes the two 16-bit fields at those offsets from the cursor, prefixes them with the state, and searches all entries in parallel. The lowest-numbered entry that matches selects the action word for that cycle.

The action word names the next state and up to two headers found by the step, each with its type and byte offset. It also gives the number of bytes to move the cursor and the offsets to use for the next lookup. Because one entry can carry two header reports, a chain of two headers can be resolved in a single cycle. A reserved next-state value ends the packet normally. A lookup that finds no match ends it as unknown. Table entries are written through a configuration port, and only while no packet is being parsed.

Top module: `parse_tcam_fsm`

## Requirements
- R1: After reset `busy` is low, `hdrVld`, `endOk` and `endMiss` are zero, and no table entry is valid, so a packet started before any write ends with `endMiss` after one lookup and reports no header.
- R2: The search key is {state[39:32], fieldA[31:16], fieldB[15:0]}. Window byte n is `pktWindow[8n+7:8n]`. Field X takes the byte at (cursor + offsetX) mod 64 as its high byte and the byte after it, also mod 64, as its low byte. Each packet starts at state 0 and cursor 0, with offset A = 12 and offset B = 0.
- R3: A key bit takes part in the comparison only where the entry's mask bit is 1. Only entries that have been written can match.
- R4: When several entries match, the action of the lowest-index matching entry is used.
- R5: The action word is laid out as next state [55:48], slot0 valid [47], slot0 type [46:39], slot0 offset [38:33], slot1 valid [32], slot1 type [31:24], slot1 offset [23:18], advance [17:12], next offset A [11:6] and next offset B [5:0]. On a hit, `hdrVld[k]` copies the valid bit of slot k. `hdrTypeK` gives its type, and `hdrOffK` gives (cursor + slot offset) mod 64.
- R6: On a hit whose next state is not 0xFF, the state becomes the next state and the cursor advances by `advance` (mod 64). Offsets A and B are replaced from the word.
- R7: On a hit whose next state is 0xFF, `endOk` pulses for one cycle together with that step's headers, and `busy` drops in the same cycle.
- R8: When no entry matches, `endMiss` pulses for one cycle with `hdrVld` zero, and the engine returns to idle.
- R9: A configuration write issued while `busy` is high has no effect on the table.
- R10: A `pktStart` sampled while idle raises `busy` on the next cycle. One lookup is made per cycle, and its reports appear one clock later. A packet that needs n lookups keeps `busy` high for exactly n cycles.
- R11: A `pktStart` sampled while `busy` is high is ignored, and no new packet begins after the current one ends.
- R12: One entry can identify two chained headers in one lookup. They are reported in the order slot0 then slot1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write strobe, honoured only when idle |
| cfgIdx | input | 5 | Entry index to write |
| cfgValue | input | 40 | Key value for the entry |
| cfgMask | input | 40 | Care mask for the entry, 1 = compare |
| cfgAction | input | 56 | Action word for the entry |
| pktStart | input | 1 | Begin parsing the window, honoured only when idle |
| pktWindow | input | 512 | Packet header bytes, byte n at bits 8n+7:8n |
| busy | output | 1 | Parsing in progress |
| hdrVld | output | 2 | Header report valid per slot |
| hdrType0 | output | 8 | Slot0 header type |
| hdrOff0 | output | 6 | Slot0 absolute header offset |
| hdrType1 | output | 8 | Slot1 header type |
| hdrOff1 | output | 6 | Slot1 absolute header offset |
| endOk | output | 1 | Packet completed through the final state |
| endMiss | output | 1 | Packet ended with no matching entry |

## Verification
The assertions assume that `pktWindow` stays unchanged from the `pktStart` that begins a packet until `endOk` or `endMiss`. They also assume the loaded graph has no cycle, so every packet terminates. The stimulus changes the window only while the engine is idle, and the table it loads only ever moves to a new state or to 0xFF. Configuration writes and start pulses are driven at the falling edge, and some are deliberately placed inside a running packet to exercise the ignore rules.

// File: rtl/parse_tbl_pkg.sv
package parse_tbl_pkg;
  localparam int STATE_W   = 8;
  localparam int LOOK_W    = 16;
  localparam int POS_W     = 6;
  localparam int TYPE_W    = 8;
  localparam int KEY_W     = STATE_W + 2 * LOOK_W;
  localparam int WIN_BYTES = 1 << POS_W;
  localparam logic [STATE_W-1:0] STATE_DONE = '1;

  typedef struct packed {
    logic [STATE_W-1:0] nextState;
    logic               h0Vld;
    logic [TYPE_W-1:0]  h0Type;
    logic [POS_W-1:0]   h0Off;
    logic               h1Vld;
    logic [TYPE_W-1:0]  h1Type;
    logic [POS_W-1:0]   h1Off;
    logic [POS_W-1:0]   advance;
    logic [POS_W-1:0]   nextOffA;
    logic [POS_W-1:0]   nextOffB;
  } action_t;

  localparam int ACT_W = $bits(action_t);

  typedef struct packed {
    logic cfgWrite;
    logic load;
    logic step;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/parse_ctrl.sv
module parse_ctrl
  import parse_tbl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pktStart,
  input  logic    cfgWe,
  input  logic    hit,
  input  logic    finalHit,
  output strobe_t strb,
  output logic    busy
);
  typedef enum logic {IDLE, RUN} mode_t;
  mode_t mode;

  assign busy = (mode == RUN);

  always_comb begin
    strb.cfgWrite = cfgWe && !busy;
    strb.load     = pktStart && !busy;
    strb.step     = busy;
    strb.finish   = busy && (!hit || finalHit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= IDLE;
    else if (strb.load) mode <= RUN;
    else if (strb.finish) mode <= IDLE;
  end

  // R7
  finish_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> !busy);

  // R11
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pktStart));
endmodule

// File: rtl/parse_dpath.sv
module parse_dpath
  import parse_tbl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter logic [STATE_W-1:0] START_STATE = '0,
  parameter logic [POS_W-1:0]   START_OFFA  = 6'd12,
  parameter logic [POS_W-1:0]   START_OFFB  = 6'd0,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobe_t                strb,
  input  logic                   busyIn,
  input  logic                   cfgWe,
  input  logic [IDX_W-1:0]       cfgIdx,
  input  logic [KEY_W-1:0]       cfgValue,
  input  logic [KEY_W-1:0]       cfgMask,
  input  logic [ACT_W-1:0]       cfgAction,
  input  logic [WIN_BYTES*8-1:0] pktWindow,
  output logic                   hit,
  output logic                   finalHit,
  output logic [1:0]             hdrVld,
  output logic [TYPE_W-1:0]      hdrType0,
  output logic [POS_W-1:0]       hdrOff0,
  output logic [TYPE_W-1:0]      hdrType1,
  output logic [POS_W-1:0]       hdrOff1,
  output logic                   endOk,
  output logic                   endMiss
);
  logic [KEY_W-1:0] tcamVal  [ENTRIES];
  logic [KEY_W-1:0] tcamMask [ENTRIES];
  action_t          ramWord  [ENTRIES];
  logic [ENTRIES-1:0] entryVld;

  logic [STATE_W-1:0] curState;
  logic [POS_W-1:0]   cursor, curOffA, curOffB;
  logic [POS_W-1:0]   posA, posA1, posB, posB1;
  logic [KEY_W-1:0]   searchKey;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   winIdx;
  action_t            winAct;

  // Table storage; valid bits are the only reset state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entryVld <= '0;
    else if (strb.cfgWrite) entryVld[cfgIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.cfgWrite) begin
      tcamVal[cfgIdx]  <= cfgValue;
      tcamMask[cfgIdx] <= cfgMask;
      ramWord[cfgIdx]  <= action_t'(cfgAction);
    end
  end

  // Lookup field selection from the window, wrapping at its end.
  function automatic logic [7:0] pickByte(input logic [WIN_BYTES*8-1:0] win,
                                          input logic [POS_W-1:0] p);
    return win[p*8 +: 8];
  endfunction

  always_comb begin
    posA  = cursor + curOffA;
    posA1 = posA + 1'b1;
    posB  = cursor + curOffB;
    posB1 = posB + 1'b1;
    searchKey = {curState,
                 pickByte(pktWindow, posA), pickByte(pktWindow, posA1),
                 pickByte(pktWindow, posB), pickByte(pktWindow, posB1)};
  end

  // Parallel ternary compare, one comparator per entry.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = entryVld[e] &&
                         (((searchKey ^ tcamVal[e]) & tcamMask[e]) == '0);
  end

  // Lowest index wins.
  always_comb begin
    winIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) winIdx = IDX_W'(e);
    end
  end

  assign winAct   = ramWord[winIdx];
  assign hit      = |matchVec;
  assign finalHit = hit && (winAct.nextState == STATE_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= START_STATE;
      cursor   <= '0;
      curOffA  <= START_OFFA;
      curOffB  <= START_OFFB;
      hdrVld   <= '0;
      hdrType0 <= '0;
      hdrOff0  <= '0;
      hdrType1 <= '0;
      hdrOff1  <= '0;
      endOk    <= 1'b0;
      endMiss  <= 1'b0;
    end else begin
      hdrVld  <= '0;
      endOk   <= 1'b0;
      endMiss <= 1'b0;
      if (strb.load) begin
        curState <= START_STATE;
        cursor   <= '0;
        curOffA  <= START_OFFA;
        curOffB  <= START_OFFB;
      end else if (strb.step) begin
        if (hit) begin
          hdrVld   <= {winAct.h1Vld, winAct.h0Vld};
          hdrType0 <= winAct.h0Type;
          hdrOff0  <= cursor + winAct.h0Off;
          hdrType1 <= winAct.h1Type;
          hdrOff1  <= cursor + winAct.h1Off;
          if (finalHit) begin
            endOk <= 1'b1;
          end else begin
            curState <= winAct.nextState;
            cursor   <= cursor + winAct.advance;
            curOffA  <= winAct.nextOffA;
            curOffB  <= winAct.nextOffB;
          end
        end else begin
          endMiss <= 1'b1;
        end
      end
    end
  end

  // R8
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({endOk, endMiss}));

  // R8
  miss_no_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    endMiss |-> (hdrVld == 2'b00));

  // R7
  finish_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> (endOk || endMiss));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyIn && cfgWe) |=> $stable(entryVld));

  // R10
  report_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hdrVld) || endOk || endMiss) |-> $past(busyIn));

  // R6
  cursor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && hit && !finalHit) |=> (cursor == $past(cursor + winAct.advance)));
endmodule

// File: rtl/parse_tcam_fsm.sv
module parse_tcam_fsm
  import parse_tbl_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgWe,
  input  logic [IDX_W-1:0]       cfgIdx,
  input  logic [KEY_W-1:0]       cfgValue,
  input  logic [KEY_W-1:0]       cfgMask,
  input  logic [ACT_W-1:0]       cfgAction,
  input  logic                   pktStart,
  input  logic [WIN_BYTES*8-1:0] pktWindow,
  output logic                   busy,
  output logic [1:0]             hdrVld,
  output logic [TYPE_W-1:0]      hdrType0,
  output logic [POS_W-1:0]       hdrOff0,
  output logic [TYPE_W-1:0]      hdrType1,
  output logic [POS_W-1:0]       hdrOff1,
  output logic                   endOk,
  output logic                   endMiss
);
  strobe_t strb;
  logic    hit, finalHit;

  parse_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pktStart (pktStart),
    .cfgWe    (cfgWe),
    .hit      (hit),
    .finalHit (finalHit),
    .strb     (strb),
    .busy     (busy)
  );

  parse_dpath #(.ENTRIES(ENTRIES)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .busyIn    (busy),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgValue  (cfgValue),
    .cfgMask   (cfgMask),
    .cfgAction (cfgAction),
    .pktWindow (pktWindow),
    .hit       (hit),
    .finalHit  (finalHit),
    .hdrVld    (hdrVld),
    .hdrType0  (hdrType0),
    .hdrOff0   (hdrOff0),
    .hdrType1  (hdrType1),
    .hdrOff1   (hdrOff1),
    .endOk     (endOk),
    .endMiss   (endMiss)
  );
endmodule

// File: tb/sim_parse_tcam_fsm.sv
module sim_parse_tcam_fsm;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfgWe = 1'b0;
  logic [4:0]   cfgIdx = '0;
  logic [39:0]  cfgValue = '0, cfgMask = '0;
  logic [55:0]  cfgAction = '0;
  logic         pktStart = 1'b0;
  logic [511:0] pktWindow = '0;
  logic         busy, endOk, endMiss;
  logic [1:0]   hdrVld;
  logic [7:0]   hdrType0, hdrType1;
  logic [5:0]   hdrOff0, hdrOff1;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  parse_tcam_fsm u0 (.*);

  typedef struct packed {
    logic [15:0] eth;
    logic [15:0] inner;
    logic [7:0]  verIhl;
    logic [7:0]  proto;
    logic [15:0] w23;
    logic [2:0]  nLook;
    logic [2:0]  nHdr;
    logic [63:0] hdrs;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0800, 16'h0000, 8'h45, 8'h06, 16'h0000, 3'd2, 3'd3, 64'h0100_030E_0422_0000, 1'b1},
    '{16'h0800, 16'h0000, 8'h45, 8'h11, 16'h0000, 3'd2, 3'd2, 64'h0100_030E_0000_0000, 1'b1},
    '{16'h8100, 16'h0800, 8'h45, 8'h06, 16'h0000, 3'd3, 3'd4, 64'h0100_020E_0312_0426, 1'b1},
    '{16'h86DD, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'd1, 3'd0, 64'h0, 1'b0},
    '{16'h0800, 16'h0000, 8'h60, 8'h06, 16'h0000, 3'd2, 3'd1, 64'h0100_0000_0000_0000, 1'b0},
    '{16'h8100, 16'h86DD, 8'h00, 8'h00, 16'h0000, 3'd2, 3'd2, 64'h0100_020E_0000_0000, 1'b0},
    '{16'h9999, 16'h0000, 8'h00, 8'h00, 16'h1234, 3'd2, 3'd1, 64'h0702_0000_0000_0000, 1'b1},
    '{16'h9999, 16'h0000, 8'h00, 8'h00, 16'h0000, 3'd2, 3'd0, 64'h0, 1'b0}
  };

  function automatic logic [55:0] mkAct(
      input logic [7:0] ns, input logic h0v, input logic [7:0] h0t, input logic [5:0] h0o,
      input logic h1v, input logic [7:0] h1t, input logic [5:0] h1o,
      input logic [5:0] adv, input logic [5:0] oa, input logic [5:0] ob);
    return {ns, h0v, h0t, h0o, h1v, h1t, h1o, adv, oa, ob};
  endfunction

  function automatic logic [511:0] buildWin(input vec_t v);
    logic [511:0] w = '0;
    int ip = (v.eth == 16'h8100) ? 18 : 14;
    w[12*8 +: 8] = v.eth[15:8];
    w[13*8 +: 8] = v.eth[7:0];
    if (v.eth == 16'h8100) begin
      w[16*8 +: 8] = v.inner[15:8];
      w[17*8 +: 8] = v.inner[7:0];
    end
    w[ip*8 +: 8]     = v.verIhl;
    w[(ip+9)*8 +: 8] = v.proto;
    w[2*8 +: 8]      = v.w23[15:8];
    w[3*8 +: 8]      = v.w23[7:0];
    return w;
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int idx, input logic [39:0] val,
                          input logic [39:0] msk, input logic [55:0] act);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 5'(idx); cfgValue = val; cfgMask = msk; cfgAction = act;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input bit midStart, input string tag);
    int looks = 0;
    int got = 0;
    bit sawOk = 0, sawMiss = 0;
    logic [15:0] gotHdr [4];
    for (int k = 0; k < 4; k++) gotHdr[k] = '0;
    pktWindow = buildWin(v);
    @(negedge clk); pktStart = 1'b1;
    @(negedge clk); pktStart = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (busy) looks++;
      pktStart = (midStart && c == 0);
      if (hdrVld[0]) begin
        if (got < 4) gotHdr[got] = {hdrType0, 2'b00, hdrOff0};
        got++;
      end
      if (hdrVld[1]) begin
        if (got < 4) gotHdr[got] = {hdrType1, 2'b00, hdrOff1};
        got++;
      end
      if (endOk || endMiss) begin
        sawOk = endOk; sawMiss = endMiss;
        break;
      end
      @(negedge clk);
    end
    pktStart = 1'b0;
    // R10: one lookup per busy cycle
    chk(looks == int'(v.nLook), "R10", {tag, " busy cycles"}, looks, int'(v.nLook));
    // R7 / R8: termination kind
    chk(sawOk == v.ok && sawMiss == !v.ok, v.ok ? "R7" : "R8", {tag, " end kind ok"},
        int'(sawOk), int'(v.ok));
    // R5 / R12: header count and order
    chk(got == int'(v.nHdr), "R12", {tag, " header count"}, got, int'(v.nHdr));
    for (int k = 0; k < 4; k++) begin
      if (k < int'(v.nHdr)) begin
        logic [15:0] e = v.hdrs[63-16*k -: 16];
        chk(gotHdr[k] == e, "R5", {tag, " header type/offset"}, int'(gotHdr[k]), int'(e));
      end
    end
    if (midStart) begin
      @(negedge clk);
      // R11: start during a packet does not launch another
      chk(busy == 1'b0, "R11", {tag, " no restart"}, int'(busy), 0);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    vec_t blank;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(hdrVld == 2'b00, "R1", "hdrVld after reset", int'(hdrVld), 0);
    chk(endOk == 1'b0, "R1", "endOk after reset", int'(endOk), 0);
    chk(endMiss == 1'b0, "R1", "endMiss after reset", int'(endMiss), 0);
    blank = '{16'h0800, 16'h0, 8'h45, 8'h06, 16'h0, 3'd1, 3'd0, 64'h0, 1'b0};
    runVec(blank, 1'b0, "R1 empty table");

    // Parse graph: R2 field selection, R3 masks, R4 priority, R6 steps
    cfgWrite(0, {8'h00, 16'h8100, 16'h0}, {8'hFF, 16'hFFFF, 16'h0},
             mkAct(8'h01, 1, 8'h01, 0, 1, 8'h02, 14, 14, 2, 0));
    cfgWrite(1, {8'h00, 16'h0800, 16'h0}, {8'hFF, 16'hFFFF, 16'h0},
             mkAct(8'h02, 1, 8'h01, 0, 0, 8'h00, 0, 14, 0, 8));
    cfgWrite(2, {8'h01, 16'h0800, 16'h0}, {8'hFF, 16'hFFFF, 16'h0},
             mkAct(8'h02, 0, 8'h00, 0, 0, 8'h00, 0, 4, 0, 8));
    cfgWrite(3, {8'h02, 16'h4500, 16'h0006}, {8'hFF, 16'hFF00, 16'h00FF},
             mkAct(8'hFF, 1, 8'h03, 0, 1, 8'h04, 20, 40, 0, 0));
    cfgWrite(4, {8'h02, 16'h4000, 16'h0}, {8'hFF, 16'hF000, 16'h0},
             mkAct(8'hFF, 1, 8'h03, 0, 0, 8'h00, 0, 20, 0, 0));
    cfgWrite(5, {8'h00, 16'h9999, 16'h0}, {8'hFF, 16'hFFFF, 16'h0},
             mkAct(8'h05, 0, 8'h00, 0, 0, 8'h00, 0, 60, 6, 0));
    cfgWrite(6, {8'h05, 16'h1234, 16'h0}, {8'hFF, 16'hFFFF, 16'h0},
             mkAct(8'hFF, 1, 8'h07, 6, 0, 8'h00, 0, 0, 0, 0));

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R12
    for (int i = 0; i < 8; i++) begin
      runVec(VECS[i], 1'b0, $sformatf("vec%0d", i));
    end

    // R9: write during a packet is dropped
    pktWindow = buildWin(VECS[0]);
    @(negedge clk); pktStart = 1'b1;
    @(negedge clk); pktStart = 1'b0;
    cfgWe = 1'b1; cfgIdx = 5'd1; cfgValue = {8'h77, 32'h0}; cfgMask = '1;
    cfgAction = mkAct(8'hFF, 1, 8'hEE, 0, 0, 8'h00, 0, 0, 0, 0);
    @(negedge clk); cfgWe = 1'b0;
    for (int c = 0; c < 10 && busy; c++) @(negedge clk);
    runVec(VECS[0], 1'b0, "R9 after busy write");

    // R11: start pulse inside a 3-lookup packet
    runVec(VECS[2], 1'b1, "R11 mid start");

    finishRun();
  end
endmodule